// File: doc/BRIEF.md
# Knockout Output Concentrator

This block is the per-output section of a knockout cell switch. Every input of the switch drives its own broadcast bus. This module listens to all `N_IN` buses at once. A filter on each bus accepts only cells whose destination field matches this output's address, `my_addr`. Each clock cycle is one cell time.

A concentrator keeps at most `L_LANES` of the accepted cells in any one cycle, taking the lowest input indices first. The rest are knocked out and counted as lost. A rotating shifter writes the surviving cells into `L_LANES` small FIFOs, round-robin, starting at a write pointer that persists from cycle to cycle. A single reader takes cells from the lanes in the same rotation, one per cycle, so the output port sees the cells in global first-in-first-out order.

`L_LANES` and `FIFO_DEPTH` must be powers of two, and `L_LANES` must not exceed `N_IN`.

Top module: `knockout_concentrator`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `lost_count` is 0 and every lane is empty.
- R2: Input i offers a cell only when `in_valid[i]` is 1 and its destination (`in_dest` bits `i*DEST_W +: DEST_W`) equals `my_addr`. Any other input is neither stored, output nor counted as lost.
- R3: In one cycle at most `L_LANES` matching cells are taken, ranked by ascending input index. Each matching cell beyond the first `L_LANES` adds one to `lost_count`.
- R4: Cells leave on `out_pay` (`in_pay` bits `i*PAY_W +: PAY_W`) in acceptance order. Cells from earlier cycles come first; cells from the same cycle come in ascending input index.
- R5: At most one cell leaves per cycle. `out_valid` is 1 after a clock edge exactly when any lane held a cell just before that edge.
- R6: A taken cell goes to lane (write pointer + cells already written this cycle) mod `L_LANES`. If that lane holds `FIFO_DEPTH` cells, the cell is dropped and counted as lost, and so is every later taken cell of that cycle. A read at the same edge does not free room until the next cycle.
- R7: A cell stored at edge t into empty storage is on `out_pay` with `out_valid` high after edge t+1.
- R8: At each edge, `lost_count` rises by exactly the number of knocked-out cells plus full-lane drops, modulo 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per cell time |
| rst_n | input | 1 | Active-low synchronous reset |
| my_addr | input | DEST_W | Address of this output, compared by the filters |
| in_valid | input | N_IN | Cell present on each broadcast bus |
| in_dest | input | N_IN*DEST_W | Destination field of each bus, packed by index |
| in_pay | input | N_IN*PAY_W | Payload word of each bus, packed by index |
| out_valid | output | 1 | A cell is on `out_pay` this cycle |
| out_pay | output | PAY_W | Payload of the departing cell |
| lost_count | output | CNT_W | Running count of knocked-out and full-drop cells |

## Verification
The assertions bound to the top module rest on two assumptions about the inputs:
- `in_valid`, `in_dest` and `my_addr` are known values at every edge.
- `N_IN` is small against 2^`CNT_W`, so the per-cycle rise of `lost_count` cannot wrap within one cycle.

The stimulus always drives defined values on every bus. It sweeps every valid mask under every address and several destination mixes, so the number of matching cells ranges from none to all `N_IN`. Its total loss stays well below the counter range, so the bench can also compare `lost_count` directly without wrap-around.

// File: rtl/knockout_concentrator.sv
module knockout_concentrator #(
  parameter int N_IN       = 8,
  parameter int L_LANES    = 4,
  parameter int FIFO_DEPTH = 4,
  parameter int PAY_W      = 16,
  parameter int DEST_W     = 3,
  parameter int CNT_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEST_W-1:0]        my_addr,
  input  logic [N_IN-1:0]          in_valid,
  input  logic [N_IN*DEST_W-1:0]   in_dest,
  input  logic [N_IN*PAY_W-1:0]    in_pay,
  output logic                     out_valid,
  output logic [PAY_W-1:0]         out_pay,
  output logic [CNT_W-1:0]         lost_count
);

  localparam int LW = (L_LANES > 1) ? $clog2(L_LANES) : 1;
  localparam int DW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int NW = $clog2(N_IN + 1);

  logic [N_IN-1:0]    hit;
  logic [CW-1:0]      cnt  [L_LANES];
  logic [PAY_W-1:0]   head [L_LANES];
  logic [L_LANES-1:0] lane_any;
  logic [L_LANES-1:0] lane_we;
  logic [PAY_W-1:0]   lane_wd [L_LANES];
  logic [NW-1:0]      drop_n;
  logic [LW-1:0]      wr_adv;
  logic [LW-1:0]      wr_ptr, rd_ptr;
  logic               rd_en;

  for (genvar i = 0; i < N_IN; i++) begin : g_filter
    assign hit[i] = in_valid[i] && (in_dest[i*DEST_W +: DEST_W] == my_addr);
  end

  always_comb begin
    logic [NW-1:0] taken;
    logic          blocked;
    logic [LW-1:0] lane;
    taken   = '0;
    blocked = 1'b0;
    lane    = '0;
    lane_we = '0;
    drop_n  = '0;
    wr_adv  = '0;
    for (int k = 0; k < L_LANES; k++) lane_wd[k] = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (hit[i]) begin
        if (taken >= NW'(L_LANES) || blocked) begin
          drop_n = drop_n + 1'b1;
        end else begin
          lane = LW'(wr_ptr + wr_adv);
          if (cnt[lane] == CW'(FIFO_DEPTH)) begin
            blocked = 1'b1;
            drop_n  = drop_n + 1'b1;
          end else begin
            lane_we[lane] = 1'b1;
            lane_wd[lane] = in_pay[i*PAY_W +: PAY_W];
            wr_adv        = wr_adv + 1'b1;
          end
        end
        taken = taken + 1'b1;
      end
    end
  end

  assign rd_en = (cnt[rd_ptr] != '0);

  for (genvar k = 0; k < L_LANES; k++) begin : g_lane
    logic [PAY_W-1:0] mem [FIFO_DEPTH];
    logic [DW-1:0]    wp, rp;
    logic             pop;
    assign pop         = rd_en && (rd_ptr == LW'(k));
    assign head[k]     = mem[rp];
    assign lane_any[k] = (cnt[k] != '0);

    always_ff @(posedge clk) begin
      if (lane_we[k]) mem[wp] <= lane_wd[k];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp     <= '0;
        rp     <= '0;
        cnt[k] <= '0;
      end else begin
        if (lane_we[k]) wp <= DW'(wp + 1'b1);
        if (pop)        rp <= DW'(rp + 1'b1);
        cnt[k] <= cnt[k] + CW'(lane_we[k]) - CW'(pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      out_valid  <= 1'b0;
      out_pay    <= '0;
      lost_count <= '0;
    end else begin
      wr_ptr     <= LW'(wr_ptr + wr_adv);
      out_valid  <= rd_en;
      lost_count <= lost_count + CNT_W'(drop_n);
      if (rd_en) begin
        out_pay <= head[rd_ptr];
        rd_ptr  <= LW'(rd_ptr + 1'b1);
      end
    end
  end

endmodule

// File: rtl/knockout_concentrator_chk.sv
module knockout_concentrator_chk #(
  parameter int N_IN    = 8,
  parameter int L_LANES = 4,
  parameter int DEST_W  = 3,
  parameter int CNT_W   = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [DEST_W-1:0]      my_addr,
  input logic [N_IN-1:0]        in_valid,
  input logic [N_IN*DEST_W-1:0] in_dest,
  input logic                   out_valid,
  input logic [CNT_W-1:0]       lost_count,
  input logic [L_LANES-1:0]     lane_any
);

  int              nhit;
  logic [CNT_W-1:0] prev_lost;
  logic [CNT_W-1:0] delta;

  always_comb begin
    nhit = 0;
    for (int i = 0; i < N_IN; i++)
      if (in_valid[i] && in_dest[i*DEST_W +: DEST_W] == my_addr) nhit++;
  end

  always_ff @(posedge clk) prev_lost <= lost_count;
  assign delta = lost_count - prev_lost;

  AST_NO_STRAY_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nhit) == 0) |-> delta == '0); // R2

  AST_KNOCK_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(nhit) > L_LANES) |-> int'(delta) >= $past(nhit) - L_LANES); // R3

  AST_LOSS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(delta) <= $past(nhit)); // R8

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lane_any) == '0) |-> !out_valid); // R5

  AST_DRAIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lane_any) != '0) |-> out_valid); // R5

endmodule

bind knockout_concentrator knockout_concentrator_chk #(
  .N_IN(N_IN), .L_LANES(L_LANES), .DEST_W(DEST_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .in_valid(in_valid),
  .in_dest(in_dest), .out_valid(out_valid), .lost_count(lost_count),
  .lane_any(lane_any)
);

// File: tb/knockout_concentrator_tb_top.sv
`timescale 1ns/1ps
module knockout_concentrator_tb_top;
  localparam int N = 8, L = 4, D = 4, PW = 16, AW = 3, CW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   my_addr = '0;
  logic [N-1:0]    in_valid = '0;
  logic [N*AW-1:0] in_dest = '0;
  logic [N*PW-1:0] in_pay = '0;
  logic            out_valid;
  logic [PW-1:0]   out_pay;
  logic [CW-1:0]   lost_count;

  int total = 0, fails = 0;
  int q[$];
  int wseq = 0, rseq = 0, exp_lost = 0, pay_seq = 1;
  bit done = 0;

  always #10 clk = ~clk;

  knockout_concentrator dut_i (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .in_valid(in_valid),
    .in_dest(in_dest), .in_pay(in_pay), .out_valid(out_valid),
    .out_pay(out_pay), .lost_count(lost_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cell time: drive at negedge, model, advance one edge, check at next negedge.
  task automatic cell_step(input logic [N-1:0] m, input logic [N*AW-1:0] d,
                           input logic [AW-1:0] a, input string vtag, input string ltag);
    bit have_pop;
    int hp, taken, lane, occ;
    bit blocked;
    my_addr  = a;
    in_valid = m;
    in_dest  = d;
    for (int i = 0; i < N; i++) in_pay[i*PW +: PW] = PW'(pay_seq + i);
    have_pop = (q.size() > 0);
    hp = have_pop ? q[0] : 0;
    taken = 0;
    blocked = 0;
    for (int i = 0; i < N; i++) begin
      if (m[i] && d[i*AW +: AW] == a) begin
        if (taken >= L || blocked) exp_lost++;
        else begin
          lane = wseq % L;
          occ = 0;
          for (int s = rseq; s < wseq; s++) if (s % L == lane) occ++;
          if (occ >= D) begin blocked = 1; exp_lost++; end
          else begin q.push_back((pay_seq + i) & 16'hffff); wseq++; end
        end
        taken++;
      end
    end
    if (have_pop) begin void'(q.pop_front()); rseq++; end
    pay_seq = (pay_seq + N) & 16'hffff;
    @(posedge clk);
    @(negedge clk);
    check(out_valid == have_pop, vtag, int'(out_valid), int'(have_pop));
    if (have_pop) check(int'(out_pay) == hp, "R4", int'(out_pay), hp);
    check(int'(lost_count) == (exp_lost & 16'hffff), ltag, int'(lost_count), exp_lost & 16'hffff);
  endtask

  function automatic logic [N*AW-1:0] dests(input logic [AW-1:0] a, input int p);
    logic [N*AW-1:0] r;
    for (int i = 0; i < N; i++)
      r[i*AW +: AW] = (p != 0 && (i + p) % 3 == 0) ? AW'(a + 1) : a;
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(lost_count == '0, "R1", int'(lost_count), 0);
    rst_n = 1'b1;
    cell_step('0, '0, '0, "R1", "R1");

    // R7: single cell into empty storage
    cell_step(8'b0000_0100, dests(3'd2, 0), 3'd2, "R7", "R8");
    cell_step('0, '0, 3'd2, "R7", "R8");
    cell_step('0, '0, 3'd2, "R5", "R8");

    // R2: all valid, none addressed here
    for (int k = 0; k < 4; k++) cell_step('1, dests(3'd6, 0), 3'd1, "R2", "R2");

    // Sweep: every address, every mask, three destination mixes, then drain
    for (int a = 0; a < 8; a++) begin
      for (int m = 0; m < 256; m++) begin
        cell_step(N'(m), dests(AW'(a), m % 3), AW'(a), "R5", "R3");
        cell_step('0, '0, AW'(a), "R5", "R8");
        if (m % 2 == 0) cell_step('0, '0, AW'(a), "R5", "R8");
      end
    end

    // R6: saturate so lanes fill and drop
    for (int k = 0; k < 30; k++) cell_step('1, dests(3'd4, 0), 3'd4, "R5", "R6");
    for (int k = 0; k < 20; k++) cell_step('0, '0, 3'd4, "R5", "R6");
    // R3: partial saturation with mixed destinations
    for (int k = 0; k < 40; k++) cell_step(8'hF5, dests(3'd7, 1 + k % 2), 3'd7, "R4", "R3");
    for (int k = 0; k < 20; k++) cell_step('0, '0, 3'd7, "R5", "R8");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule